// File: doc/BRIEF.md
# I2C Slave Address Decision Unit

This block sits behind the bit-level receiver of an I2C slave and decides, byte by byte, whether the address phase of a transfer is meant for this device. The receiver hands over each deserialized byte with a strobe, plus a flag that marks the first byte after a START or repeated START. One cycle later the block answers with an acknowledge decision. When the byte completes a match, it also raises a one-cycle matched event and captures the 7-bit address code and the transfer direction.

Two programmable own addresses are supported. The first is either a 7-bit or a 10-bit address. The second is a 7-bit address with a progressive don't-care mask over its low bits. The block also recognises the general call address and three SMBus special addresses, each behind its own enable. For a 10-bit address, the header byte is acknowledged first, and the matched event fires only when the second byte also compares equal. Each own address and its mode or mask is held in a local register, and that register loads only while the address's enable is low.

Top module: `slv_addr_decider`

## Requirements
- R1: After reset, `ack_vld`, `ack`, `hit`, `code` and `dir` are all zero.
- R2: With own address 1 enabled in 7-bit mode, a first byte whose bits [7:1] equal own-address bits [7:1] is ACKed (`ack`=1) and matched. Own-address bits 9, 8 and 0 play no part in the compare.
- R3: With own address 1 enabled in 10-bit mode, a first byte of 11110 followed by own-address bits [9:8] and R/W=0 is ACKed without `hit`. If the next non-first byte equals own-address bits [7:0], it is ACKed with `hit`=1 and `code` = header bits [7:1]. Any other next byte is NACKed and leaves `code` and `dir` unchanged.
- R4: With own address 2 enabled and mask value k (0..7), only address bits [6:k] are compared against own address 2. With k=7, every non-reserved 7-bit address is ACKed.
- R5: When the mask value is nonzero, addresses 0000xxx and 1111xxx are never ACKed through own address 2, even when the masked compare agrees.
- R6: An address that matches an own address whose enable is low, and matches no other enabled source, is NACKed (`ack_vld`=1, `ack`=0, `hit`=0).
- R7: Address 0000000 is ACKed when `gc_en` is 1 and is NACKed when it is 0 and no other source matches.
- R8: Address 0001000 is ACKed only when `host_en` is 1. Address 1100001 is ACKed only when `dflt_en` is 1.
- R9: Address 0001100 is ACKed only when `alert_en` is 1 and `host_en` is 0.
- R10: On a matched event, `code` takes the received 7-bit address and `dir` takes the R/W bit (0 = slave receives, 1 = slave transmits). Both hold their value until the next matched event.
- R11: The registered outputs change in the cycle after the strobe. `ack_vld` and `hit` are single-cycle pulses. A non-first byte that arrives while no 10-bit header is pending gives no decision.
- R12: Values presented on an own address's value, mode or mask inputs while that address's enable is high have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Strobe for a received byte |
| byte_data | input | 8 | Received byte; bit 0 is R/W on a first byte |
| byte_first | input | 1 | Byte is the first one after a (repeated) START |
| oa1_val | input | 10 | Own address 1 value |
| oa1_wide | input | 1 | Own address 1 is 10-bit |
| oa1_en | input | 1 | Own address 1 enable; config loads while low |
| oa2_val | input | 7 | Own address 2 (7-bit) |
| oa2_mask | input | 3 | Number of low own-address-2 bits that are don't care |
| oa2_en | input | 1 | Own address 2 enable; config loads while low |
| gc_en | input | 1 | General call acceptance |
| host_en | input | 1 | SMBus host address acceptance |
| dflt_en | input | 1 | SMBus device default address acceptance |
| alert_en | input | 1 | Alert response address acceptance |
| ack_vld | output | 1 | Decision pulse |
| ack | output | 1 | 1 = ACK, 0 = NACK, valid with ack_vld |
| hit | output | 1 | Address matched event pulse |
| code | output | 7 | Captured 7-bit address code |
| dir | output | 1 | Captured transfer direction |

## Verification
The bench uses the default widths: 7-bit codes, a 10-bit own address and a 3-bit mask. With these widths every mask value from 0 through 7 can be exercised, including the mask that removes the compare entirely, and both reserved prefixes can be hit. Random configurations push own addresses onto the SMBus special codes and the reserved ranges, so the overlaps between sources are reached. Directed sequences cover the 10-bit header and its second byte, and configuration changes made while an enable is high.

// File: rtl/sam_pkg.sv
package sam_pkg;
    localparam int CODE_W = 7;
    localparam int WIDE_W = 10;
    localparam int MASK_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_TEN_LO = 1'b1
    } sam_state_e;

    typedef struct packed {
        sam_state_e          st;
        logic                ack_vld;
        logic                ack;
        logic                hit;
        logic [CODE_W-1:0]   code;
        logic                dir;
        logic [CODE_W-1:0]   hdr;
    } sam_regs_t;
endpackage

// File: rtl/sam_cfg_hold.sv
module sam_cfg_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = lock ? val_q : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign dout = val_q;
endmodule

// File: rtl/sam_mask_cmp.sv
module sam_mask_cmp #(
    parameter int AW = 7,
    parameter int MW = 3
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] own,
    input  logic [MW-1:0] mask,
    output logic          match
);
    logic [AW-1:0] bit_ok;
    logic          reserved;
    logic          raw;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        localparam logic [MW:0] IDX = (MW+1)'(i);
        always_comb begin
            if (IDX >= {1'b0, mask}) bit_ok[i] = (addr[i] == own[i]);
            else                      bit_ok[i] = 1'b1;
        end
    end

    always_comb begin
        raw      = &bit_ok;
        reserved = (addr[AW-1:AW-4] == 4'b0000) || (addr[AW-1:AW-4] == 4'b1111);
        match    = raw && !((mask != '0) && reserved);
    end
endmodule

// File: rtl/sam_fixed_match.sv
module sam_fixed_match #(
    parameter int            AW      = 7,
    parameter logic [AW-1:0] GC_CODE = 7'h00,
    parameter logic [AW-1:0] HOST    = 7'h08,
    parameter logic [AW-1:0] DFLT    = 7'h61,
    parameter logic [AW-1:0] ALRT    = 7'h0C
) (
    input  logic [AW-1:0] addr,
    input  logic          gc_en,
    input  logic          host_en,
    input  logic          dflt_en,
    input  logic          alert_en,
    output logic          match
);
    always_comb begin
        match = ((addr == GC_CODE) && gc_en)
             || ((addr == HOST)    && host_en)
             || ((addr == DFLT)    && dflt_en)
             || ((addr == ALRT)    && alert_en && !host_en);
    end
endmodule

// File: rtl/slv_addr_decider.sv
module slv_addr_decider
    import sam_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int WW = WIDE_W,
    parameter int MW = MASK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [CW:0]   byte_data,
    input  logic          byte_first,
    input  logic [WW-1:0] oa1_val,
    input  logic          oa1_wide,
    input  logic          oa1_en,
    input  logic [CW-1:0] oa2_val,
    input  logic [MW-1:0] oa2_mask,
    input  logic          oa2_en,
    input  logic          gc_en,
    input  logic          host_en,
    input  logic          dflt_en,
    input  logic          alert_en,
    output logic          ack_vld,
    output logic          ack,
    output logic          hit,
    output logic [CW-1:0] code,
    output logic          dir
);
    localparam int HI_W = WW - CW - 1;
    localparam int PFX_W = CW - HI_W;
    localparam logic [PFX_W-1:0] TEN_PFX = '1 << 1;

    sam_regs_t r_d, r_q;

    logic [WW:0]      oa1_cfg;
    logic [CW+MW-1:0] oa2_cfg;
    logic [WW-1:0]    oa1_addr;
    logic             oa1_is_wide;
    logic [CW-1:0]    oa2_addr;
    logic [MW-1:0]    oa2_msk;

    sam_cfg_hold #(.W(WW+1)) u_oa1_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .lock (oa1_en),
        .din  ({oa1_wide, oa1_val}),
        .dout (oa1_cfg)
    );

    sam_cfg_hold #(.W(CW+MW)) u_oa2_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .lock (oa2_en),
        .din  ({oa2_mask, oa2_val}),
        .dout (oa2_cfg)
    );

    assign oa1_addr    = oa1_cfg[WW-1:0];
    assign oa1_is_wide = oa1_cfg[WW];
    assign oa2_addr    = oa2_cfg[CW-1:0];
    assign oa2_msk     = oa2_cfg[CW+MW-1:CW];

    logic [CW-1:0] rx_code;
    logic          rx_rw;
    logic          oa2_match, fixed_match;

    assign rx_code = byte_data[CW:1];
    assign rx_rw   = byte_data[0];

    sam_mask_cmp #(.AW(CW), .MW(MW)) u_oa2_cmp (
        .addr (rx_code),
        .own  (oa2_addr),
        .mask (oa2_msk),
        .match(oa2_match)
    );

    sam_fixed_match #(.AW(CW)) u_fixed (
        .addr    (rx_code),
        .gc_en   (gc_en),
        .host_en (host_en),
        .dflt_en (dflt_en),
        .alert_en(alert_en),
        .match   (fixed_match)
    );

    logic oa1_short_hit, ten_hdr_hit, ten_lo_hit, any_short;

    always_comb begin
        oa1_short_hit = oa1_en && !oa1_is_wide && (rx_code == oa1_addr[CW:1]);
        ten_hdr_hit   = oa1_en && oa1_is_wide && !rx_rw
                     && (rx_code == {TEN_PFX, oa1_addr[WW-1:CW+1]});
        ten_lo_hit    = oa1_en && oa1_is_wide && (byte_data == oa1_addr[CW:0]);
        any_short     = oa1_short_hit || (oa2_en && oa2_match) || fixed_match;
    end

    always_comb begin
        r_d         = r_q;
        r_d.ack_vld = 1'b0;
        r_d.hit     = 1'b0;
        if (byte_vld) begin
            if (!byte_first && (r_q.st == ST_TEN_LO)) begin
                r_d.st      = ST_IDLE;
                r_d.ack_vld = 1'b1;
                r_d.ack     = ten_lo_hit;
                if (ten_lo_hit) begin
                    r_d.hit  = 1'b1;
                    r_d.code = r_q.hdr;
                    r_d.dir  = 1'b0;
                end
            end else if (byte_first) begin
                r_d.st      = ST_IDLE;
                r_d.ack_vld = 1'b1;
                if (ten_hdr_hit) begin
                    r_d.ack = 1'b1;
                    r_d.st  = ST_TEN_LO;
                    r_d.hdr = rx_code;
                end else if (any_short) begin
                    r_d.ack  = 1'b1;
                    r_d.hit  = 1'b1;
                    r_d.code = rx_code;
                    r_d.dir  = rx_rw;
                end else begin
                    r_d.ack = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ack_vld = r_q.ack_vld;
    assign ack     = r_q.ack_vld & r_q.ack;
    assign hit     = r_q.hit;
    assign code    = r_q.code;
    assign dir     = r_q.dir;
endmodule

// File: rtl/sam_check.sv
module sam_check #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_vld,
    input logic          ack_vld,
    input logic          ack,
    input logic          hit,
    input logic [CW-1:0] code,
    input logic          dir
);
    p_hit_acks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (ack_vld && ack));

    p_hold_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> ($stable(code) && $stable(dir)));

    p_vld_follows_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_vld));

    p_hit_follows_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(byte_vld));

    p_nack_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !ack) |-> !hit);
endmodule

bind slv_addr_decider sam_check #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_vld(byte_vld),
    .ack_vld (ack_vld),
    .ack     (ack),
    .hit     (hit),
    .code    (code),
    .dir     (dir)
);

// File: tb/sim_slv_addr_decider.sv
module sim_slv_addr_decider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_first = 1'b0;
    logic [9:0] oa1_val = '0;
    logic       oa1_wide = 1'b0, oa1_en = 1'b0;
    logic [6:0] oa2_val = '0;
    logic [2:0] oa2_mask = '0;
    logic       oa2_en = 1'b0;
    logic       gc_en = 1'b0, host_en = 1'b0, dflt_en = 1'b0, alert_en = 1'b0;
    logic       ack_vld, ack, hit, dir;
    logic [6:0] code;

    always #4 clk = ~clk;

    slv_addr_decider u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_first(byte_first), .oa1_val(oa1_val), .oa1_wide(oa1_wide),
        .oa1_en(oa1_en), .oa2_val(oa2_val), .oa2_mask(oa2_mask), .oa2_en(oa2_en),
        .gc_en(gc_en), .host_en(host_en), .dflt_en(dflt_en), .alert_en(alert_en),
        .ack_vld(ack_vld), .ack(ack), .hit(hit), .code(code), .dir(dir)
    );

    int n_chk = 0, n_bad = 0;

    // bench shadow of the held configuration and of the expected state
    logic [9:0] m_oa1 = '0;
    logic       m_wide = 1'b0;
    logic [6:0] m_oa2 = '0;
    logic [2:0] m_mask = '0;
    logic       m_pend = 1'b0;
    logic [6:0] m_hdr = '0;
    logic [6:0] m_code = '0;
    logic       m_dir = 1'b0;

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual vld/ack/hit/code/dir=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic oa2_ok(input logic [6:0] a);
        logic agree;
        logic rsv;
        agree = (((a ^ m_oa2) >> m_mask) == 7'd0);
        rsv   = (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
        return oa2_en && agree && !((m_mask != 3'd0) && rsv);
    endfunction

    function automatic logic short_ok(input logic [6:0] a);
        logic r;
        r = oa1_en && !m_wide && (a == m_oa1[7:1]);
        r = r || oa2_ok(a);
        r = r || (gc_en && a == 7'h00);
        r = r || (host_en && a == 7'h08);
        r = r || (dflt_en && a == 7'h61);
        r = r || (alert_en && !host_en && a == 7'h0C);
        return r;
    endfunction

    task automatic set_oa1(input logic [9:0] v, input logic w);
        @(negedge clk);
        oa1_val = v; oa1_wide = w;
        if (!oa1_en) begin m_oa1 = v; m_wide = w; end
        @(negedge clk);
    endtask

    task automatic set_oa2(input logic [6:0] v, input logic [2:0] k);
        @(negedge clk);
        oa2_val = v; oa2_mask = k;
        if (!oa2_en) begin m_oa2 = v; m_mask = k; end
        @(negedge clk);
    endtask

    task automatic send(input string tag, input logic [7:0] b, input logic f);
        logic e_vld, e_ack, e_hit;
        logic [6:0] a;
        a = b[7:1];
        e_vld = 1'b0; e_ack = 1'b0; e_hit = 1'b0;
        if (f) begin
            e_vld = 1'b1;
            m_pend = 1'b0;
            if (oa1_en && m_wide && !b[0] && a == {5'b11110, m_oa1[9:8]}) begin
                e_ack = 1'b1; m_pend = 1'b1; m_hdr = a;
            end else if (short_ok(a)) begin
                e_ack = 1'b1; e_hit = 1'b1; m_code = a; m_dir = b[0];
            end
        end else if (m_pend) begin
            e_vld = 1'b1;
            m_pend = 1'b0;
            if (oa1_en && m_wide && b == m_oa1[7:0]) begin
                e_ack = 1'b1; e_hit = 1'b1; m_code = m_hdr; m_dir = 1'b0;
            end
        end
        @(negedge clk);
        byte_vld = 1'b1; byte_data = b; byte_first = f;
        @(negedge clk);
        byte_vld = 1'b0;
        check(tag, {ack_vld, ack, hit, code, dir}, {e_vld, e_ack, e_hit, m_code, m_dir});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check("R1", {ack_vld, ack, hit, code, dir}, 11'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {ack_vld, ack, hit, code, dir}, 11'd0);

        // R2: 7-bit own address 1, bits 9/8/0 ignored
        set_oa1(10'h3A5, 1'b0);
        oa1_en = 1'b1;
        send("R2", 8'hA5, 1'b1);
        send("R2", 8'hA4, 1'b1);
        send("R2", 8'hA7, 1'b1);
        // R11: data byte without pending header gives no decision
        send("R11", 8'h55, 1'b0);
        // R12: change while enabled is ignored
        set_oa1(10'h022, 1'b1);
        send("R12", 8'hA4, 1'b1);
        send("R12", 8'h22, 1'b1);
        // R6: enable low
        oa1_en = 1'b0;
        send("R6", 8'hA4, 1'b1);

        // R3: 10-bit addressing
        set_oa1(10'h2C3, 1'b1);
        oa1_en = 1'b1;
        send("R3", 8'hF4, 1'b1);
        send("R3", 8'hC3, 1'b0);
        send("R3", 8'hF4, 1'b1);
        send("R3", 8'hC2, 1'b0);
        send("R3", 8'hF5, 1'b1);
        send("R3", 8'hF6, 1'b1);
        oa1_en = 1'b0;

        // R4/R5: own address 2 masks
        for (int k = 0; k < 8; k++) begin
            set_oa2(7'h5A, 3'(k));
            oa2_en = 1'b1;
            send("R4", {7'h5A ^ 7'((1 << k) >> 1), 1'b1}, 1'b1);
            send("R4", {7'h5A ^ 7'(1 << k), 1'b0}, 1'b1);
            send("R5", {7'h03, 1'b0}, 1'b1);
            send("R5", {7'h7C, 1'b1}, 1'b1);
            oa2_en = 1'b0;
        end
        set_oa2(7'h79, 3'd0);
        oa2_en = 1'b1;
        send("R5", {7'h79, 1'b0}, 1'b1);
        oa2_en = 1'b0;

        // R7/R8/R9 special addresses
        send("R7", 8'h00, 1'b1);
        gc_en = 1'b1;  send("R7", 8'h00, 1'b1);  gc_en = 1'b0;
        send("R8", 8'h10, 1'b1);
        host_en = 1'b1; send("R8", 8'h11, 1'b1);
        alert_en = 1'b1; send("R9", 8'h18, 1'b1);
        host_en = 1'b0; send("R9", 8'h19, 1'b1);
        alert_en = 1'b0; send("R9", 8'h18, 1'b1);
        send("R8", 8'hC2, 1'b1);
        dflt_en = 1'b1; send("R8", 8'hC3, 1'b1); dflt_en = 1'b0;

        // R10: random mix
        for (int it = 0; it < 600; it++) begin
            if (it % 40 == 0) begin
                @(negedge clk);
                oa1_en = 1'b0; oa2_en = 1'b0;
                set_oa1(10'($urandom), 1'($urandom));
                set_oa2(7'($urandom), 3'($urandom));
                @(negedge clk);
                oa1_en = 1'($urandom); oa2_en = 1'($urandom);
                gc_en = 1'($urandom); host_en = 1'($urandom);
                dflt_en = 1'($urandom); alert_en = 1'($urandom);
                if ($urandom % 3 == 0) set_oa1(10'($urandom), 1'($urandom));
            end
            begin
                logic [7:0] b;
                int sel;
                sel = $urandom % 8;
                case (sel)
                    0: b = {m_oa1[7:1], 1'($urandom)};
                    1: b = {m_oa2 ^ 7'($urandom % 4), 1'($urandom)};
                    2: b = {7'h08, 1'($urandom)};
                    3: b = {7'h0C, 1'($urandom)};
                    4: b = {7'h61, 1'($urandom)};
                    5: b = {5'b11110, m_oa1[9:8], 1'b0};
                    6: b = m_oa1[7:0];
                    default: b = 8'($urandom);
                endcase
                send("R10", b, (sel == 6) ? 1'b0 : 1'($urandom % 4 != 0));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule